// File: doc/BRIEF.md
# First-Error Capture and Lockout Logger

This block collects single-cycle error event pulses from many sources into detection bits. The bits live in a small bank of status registers. When an enabled event arrives and no detection bit is set, the block latches it, and every other enabled event in that same clock is latched with it. From then on the logger is locked: further events are dropped until software has cleared every detection bit in every register. Software clears a bit by writing a one to it.

A level machine-check request goes to the processor while any bit in a configurable machine-check class is set and the global machine-check enable is high. The system-error event at flat index 7 (register 0, bit 7) belongs to that class by default. A separate sideband interrupt input also drives the request, but only while its own enable is set, and it is never logged. Register count, register width, the set of implemented bits and the machine-check class are all parameters.

Top module: `elog_first_err`

## Requirements
- R1: After reset every detection bit reads 0 and `mc_o` is low.
- R2: With all detection bits clear, an event pulse on `evt_i[k]` with `evt_en_i[k]` high sets detection bit k at the next clock edge. Flat bit k is bit k%REG_W of register k/REG_W.
- R3: While any detection bit is set, no event pulse sets any further bit.
- R4: Several enabled events in the same clock while all bits are clear are all latched together.
- R5: A write sets `reg_wr_i` high with `reg_addr_i` selecting the register. Each one in `reg_wdata_i` clears the matching bit at the next edge, and each zero leaves its bit unchanged. Addresses at or above NUM_REGS read 0 and ignore writes.
- R6: Logging resumes only once all bits in all registers are clear. An event that arrives in the same clock as the write clearing the last set bit is dropped.
- R7: An event whose `evt_en_i` bit is low sets nothing.
- R8: Bits outside IMPL_MASK (default 0x1B39F7 over the flat vector) always read 0 and never set.
- R9: A set bit in MC_MASK (default 0x000881, which includes flat bit 7) drives `mc_o` high while `mc_en_i` is high. `mc_o` stays high as long as such a bit stays set, and drops once that bit is cleared.
- R10: With `mc_en_i` low, set detection bits do not raise `mc_o`, but the bits are still logged.
- R11: `nmi_i` raises `mc_o` in the same cycle only while `nmi_mc_en_i` is high, and it sets no detection bit.
- R12: Set bits outside MC_MASK do not raise `mc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_REGS*REG_W | Error event pulses, one per flat detection bit |
| evt_en_i | input | NUM_REGS*REG_W | Per-event enables |
| mc_en_i | input | 1 | Global machine-check enable for logged bits |
| nmi_i | input | 1 | Sideband interrupt input |
| nmi_mc_en_i | input | 1 | Enable for the sideband interrupt to raise the machine check |
| reg_addr_i | input | AW | Register select |
| reg_wr_i | input | 1 | Write strobe, write-one-to-clear |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data of the selected register (combinational) |
| mc_o | output | 1 | Level machine-check request |

## Verification
The hardest case to reach is an event that lands in the same clock as the write that empties the last non-empty register. The logger must drop that event, although one cycle later it would be latched. The bench reaches this case from every pair of first and second event sources. It latches the first event, tries the second event under lockout, and then clears in two steps. It clears register 0 alone first, and then the remaining registers, firing the second event again on the final write. A reference model computed in the bench predicts each state.

// File: rtl/elog_pkg.sv
package elog_pkg;
   // flat index of the system-error detection bit (register 0, bit 7)
   localparam int SERR_BIT = 7;

   function automatic int addr_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/elog_bank.sv
module elog_bank #(
   parameter int               REG_W = 8,
   parameter logic [REG_W-1:0] IMPL  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_i,
   input  logic [REG_W-1:0] set_i,
   input  logic [REG_W-1:0] clr_i,
   output logic [REG_W-1:0] det_o
);
   logic [REG_W-1:0] det_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      det_q <= '0;
      else if (!lock_i) det_q <= set_i & IMPL;
      else             det_q <= det_q & ~clr_i;
   end

   assign det_o = det_q;

   AST_LOCK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> ((det_o & ~$past(det_o)) == '0));                    // R3
   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> ((det_o & $past(clr_i)) == '0));                     // R5
   AST_IDLE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_i |=> (det_o == ($past(set_i) & IMPL)));                  // R4
   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (det_o & ~IMPL) == '0);                                         // R8
endmodule

// File: rtl/elog_lock.sv
module elog_lock #(
   parameter int NBITS = 24
) (
   input  logic [NBITS-1:0] det_i,
   output logic             lock_o
);
   assign lock_o = |det_i;
endmodule

// File: rtl/elog_mcgen.sv
module elog_mcgen #(
   parameter int               NBITS       = 24,
   parameter logic [NBITS-1:0] MC_MASK     = '0,
   parameter bit               NMI_PRESENT = 1'b1
) (
   input  logic [NBITS-1:0] det_i,
   input  logic             mc_en_i,
   input  logic             nmi_i,
   input  logic             nmi_en_i,
   output logic             mc_o
);
   logic det_mc;
   logic side_mc;

   assign det_mc = mc_en_i & (|(det_i & MC_MASK));

   if (NMI_PRESENT) begin : g_nmi
      assign side_mc = nmi_i & nmi_en_i;
   end else begin : g_no_nmi
      assign side_mc = 1'b0;
   end

   assign mc_o = det_mc | side_mc;
endmodule

// File: rtl/elog_first_err.sv
module elog_first_err #(
   parameter int  NUM_REGS    = 3,
   parameter int  REG_W       = 8,
   parameter logic [NUM_REGS*REG_W-1:0] IMPL_MASK = 24'h1B39F7,
   parameter logic [NUM_REGS*REG_W-1:0] MC_MASK   = 24'h000881,
   parameter bit  NMI_PRESENT = 1'b1,
   localparam int NBITS       = NUM_REGS * REG_W,
   localparam int AW          = elog_pkg::addr_width(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] evt_i,
   input  logic [NBITS-1:0] evt_en_i,
   input  logic             mc_en_i,
   input  logic             nmi_i,
   input  logic             nmi_mc_en_i,
   input  logic [AW-1:0]    reg_addr_i,
   input  logic             reg_wr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   output logic [REG_W-1:0] reg_rdata_o,
   output logic             mc_o
);
   import elog_pkg::*;

   if (NUM_REGS < 1) begin : g_bad_regs
      $error("NUM_REGS must be at least 1");
   end
   if (REG_W < 1 || REG_W > 32) begin : g_bad_width
      $error("REG_W must be within 1..32");
   end

   logic [NBITS-1:0] det_flat;
   logic [NBITS-1:0] set_flat;
   logic             lock;

   assign set_flat = evt_i & evt_en_i;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_bank
      logic [REG_W-1:0] clr;
      assign clr = (reg_wr_i && (int'(reg_addr_i) == r)) ? reg_wdata_i : '0;

      elog_bank #(
         .REG_W (REG_W),
         .IMPL  (IMPL_MASK[r*REG_W +: REG_W])
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .lock_i (lock),
         .set_i  (set_flat[r*REG_W +: REG_W]),
         .clr_i  (clr),
         .det_o  (det_flat[r*REG_W +: REG_W])
      );
   end

   elog_lock #(.NBITS(NBITS)) u_lock (
      .det_i  (det_flat),
      .lock_o (lock)
   );

   elog_mcgen #(
      .NBITS       (NBITS),
      .MC_MASK     (MC_MASK),
      .NMI_PRESENT (NMI_PRESENT)
   ) u_mc (
      .det_i    (det_flat),
      .mc_en_i  (mc_en_i),
      .nmi_i    (nmi_i),
      .nmi_en_i (nmi_mc_en_i),
      .mc_o     (mc_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (int'(reg_addr_i) == r) reg_rdata_o = det_flat[r*REG_W +: REG_W];
      end
   end

   AST_MC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!mc_en_i && !(nmi_i && nmi_mc_en_i)) |-> !mc_o);               // R10
   AST_NMI_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (NMI_PRESENT && nmi_i && nmi_mc_en_i) |-> mc_o);                // R11
   AST_SERR_MC: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock && set_flat[SERR_BIT] && IMPL_MASK[SERR_BIT] && MC_MASK[SERR_BIT])
      |=> (mc_o || !mc_en_i));                                        // R9
   AST_RESUME_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> ((det_flat & ~$past(det_flat)) == '0));                // R6
endmodule

// File: tb/elog_first_err_tb.sv
`timescale 1ns/1ps
module elog_first_err_tb;
   localparam int NR = 3;
   localparam int W  = 8;
   localparam int NB = NR * W;
   localparam logic [NB-1:0] IMPL = 24'h1B39F7;
   localparam logic [NB-1:0] MCM  = 24'h000881;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [NB-1:0] evt = '0;
   logic [NB-1:0] en  = '1;
   logic          mc_en = 1;
   logic          nmi = 0;
   logic          nmi_en = 0;
   logic [1:0]    addr = '0;
   logic          wr = 0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata;
   logic          mc;

   int n_chk = 0;
   int n_bad = 0;
   logic [NB-1:0] exp_det = '0;

   always #10 clk = ~clk;

   elog_first_err u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .evt_en_i(en), .mc_en_i(mc_en),
      .nmi_i(nmi), .nmi_mc_en_i(nmi_en), .reg_addr_i(addr), .reg_wr_i(wr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mc_o(mc)
   );

   initial begin
      #4000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish (got hang, expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // bench reference for one clock given the event and clear vectors
   function automatic logic [NB-1:0] step(input logic [NB-1:0] d,
         input logic [NB-1:0] e, input logic [NB-1:0] c);
      if (d == '0) return e & en & IMPL;
      return d & ~c;
   endfunction

   function automatic logic exp_mc();
      return (mc_en && ((exp_det & MCM) != '0)) || (nmi && nmi_en);
   endfunction

   task automatic check_all(input string req);
      for (int r = 0; r < 4; r++) begin
         addr = r[1:0];
         #1;
         chk(req, {24'h0, rdata}, (r < NR) ? {24'h0, exp_det[r*W +: W]} : 32'h0);
      end
      chk({req, " mc"}, {31'h0, mc}, {31'h0, exp_mc()});
   endtask

   // one cycle: optional event vector and optional clear write
   task automatic cyc(input logic [NB-1:0] e, input logic do_wr,
         input int a, input logic [W-1:0] d);
      logic [NB-1:0] c;
      c = '0;
      if (do_wr && a < NR) c[a*W +: W] = d;
      @(negedge clk);
      evt = e; wr = do_wr; addr = a[1:0]; wdata = d;
      @(negedge clk);
      evt = '0; wr = 0;
      exp_det = step(exp_det, e, c);
   endtask

   task automatic clear_all();
      for (int r = 0; r < NR; r++) cyc('0, 1, r, '1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      rst_n = 1;
      @(negedge clk);
      check_all("R1 after reset");

      // pair sweep: first event i, second event j
      for (int i = 0; i < NB; i++) begin
         for (int j = 0; j < NB; j++) begin
            mc_en = ((i + j) % 3) != 0;
            cyc(NB'(1) << i, 0, 0, '0);
            check_all("R2/R8/R9/R10/R12 first event");
            cyc(NB'(1) << j, 0, 0, '0);
            check_all("R3 lockout");
            cyc('0, 1, 0, 8'h55);
            check_all("R5 partial clear");
            cyc('0, 1, 0, '1);
            cyc('0, 1, 3, '1);
            check_all("R5 out-of-range write");
            cyc('0, 1, 1, '1);
            // final clear together with an event: event must be dropped
            cyc(NB'(1) << j, 1, 2, '1);
            check_all("R6 clear-with-event");
            if (exp_det != '0) clear_all();
         end
      end
      mc_en = 1;

      // R4: simultaneous events, sweep of multi-bit patterns
      for (int k = 0; k < 64; k++) begin
         logic [NB-1:0] p;
         p = {NB{1'b0}} | (NB'(k * 37 + 5) << (k % 7)) | (NB'(1) << (k % NB));
         cyc(p, 0, 0, '0);
         check_all("R4 simultaneous");
         clear_all();
         check_all("R6 resumed empty");
      end

      // R7: per-event enables
      for (int k = 0; k < NB; k++) begin
         en = ~(NB'(1) << k);
         cyc(NB'(1) << k, 0, 0, '0);
         check_all("R7 disabled event");
         cyc((NB'(1) << k) | (NB'(1) << ((k + 1) % NB)), 0, 0, '0);
         check_all("R7 mixed enable");
         clear_all();
      end
      en = '1;

      // R9: mc_o held while system-error bit stays set
      cyc(NB'(1) << 7, 0, 0, '0);
      repeat (5) @(negedge clk);
      check_all("R9 level hold");
      cyc('0, 1, 0, 8'h7F);
      check_all("R9 zeros keep bit");
      cyc('0, 1, 0, 8'h80);
      check_all("R9 drop on clear");

      // R11: sideband interrupt gating, not logged
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         nmi = k[0]; nmi_en = k[1]; mc_en = k[2];
         #1;
         check_all("R11 sideband");
      end
      nmi = 0; nmi_en = 0; mc_en = 1;

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule